// File: doc/BRIEF.md
# Parallel EEPROM Page Write Engine

This block is a clocked behavioural model of the write side of a byte-wide parallel EEPROM. A host drives a synchronous bus with active-low chip select, write strobe and read strobe, a 17-bit address and 8-bit data. Each write strobe loads one byte into a page buffer. All bytes of one load session must fall in the same page, which is the group of bytes that share address bits 16 to 7. When the write strobe stays quiet for a set number of cycles, the buffered bytes are programmed into a behavioural array. Bytes that were not loaded keep their old contents.

While a load session or a program cycle is in progress, the block pulls an open-drain-style busy line. A read during that time returns a status byte instead of array data. Bit 7 of the status byte is the inverse of bit 7 of the last loaded byte. Bit 6 is a flag that alternates on every read, and the first read returns 1. An active-low protect input blocks reads and writes while it is low. If the protect input falls during a load session or a program cycle, the engine abandons that operation.

Top module: `eeprom_page_writer`

## Requirements
- R1: After `rst_n` is released, `busy_pull`, `dout_en` and `page_err` are all 0.
- R2: A byte that is loaded and then programmed reads back from the array at its address once `busy_pull` has returned to 0.
- R3: A page load of several bytes writes every loaded byte. Bytes of that page that were not loaded keep their previous array values.
- R4: The address is taken when the write strobe (`ce_n` and `we_n` both low) begins. The data is taken from the value `din` holds when the strobe ends.
- R5: `busy_pull` rises only after a byte has been loaded. Programming starts after `WIN_CYC` cycles with no write strobe and lasts `PROG_CYC` cycles, so `busy_pull` stays at 1 for `WIN_CYC + PROG_CYC` cycles after the load of the last byte.
- R6: A read while busy returns a status byte. Bit 7 is the inverse of bit 7 of the last accepted byte. Bit 6 is 1 on the first read and alternates on each later read. Bits 5 to 0 are 0.
- R7: A byte whose page (address bits 16 to 7) differs from the page of the first byte is dropped, and `page_err` is set. The flag stays set until the first byte of a new load session clears it.
- R8: While `res_n` is low, `dout_en` stays 0 and write strobes are ignored. A fall of `res_n` during a load session sends the engine to idle and releases `busy_pull`, and the abandoned bytes are never programmed.
- R9: Write strobes that arrive during the program cycle have no effect on the array.
- R10: A read (`ce_n` and `oe_n` low, `we_n` high) outside busy returns the array byte at `addr` with one cycle of latency. `dout_en` is 0 whenever `ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the engine state |
| res_n | input | 1 | Active-low protect/abort input |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read strobe |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | Read data valid (output driver enable) |
| busy_pull | output | 1 | 1 while the busy line is pulled low |
| page_err | output | 1 | Sticky flag: a byte for another page was dropped |

## Verification
The embedded properties check five things on every cycle:
- a program cycle is entered only from a load session;
- the engine returns to idle one cycle after the protect input is seen low;
- the busy line rises only after a byte load;
- the buffer's valid mask does not move during programming;
- the page error flag rises only after a rejected load.

Some behaviour is visible only through the bench scenarios:
- the data that actually lands in the array, and the preservation of unloaded bytes;
- the capture points of address and data within one strobe;
- the exact length of the busy period;
- the alternating status bit across successive reads.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_PROG = 2'd2
  } sq_state_t;
endpackage

// File: rtl/eepw_strobe.sv
// Registers the host pins and derives write/read strobe events.
module eepw_strobe #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          res_ok,
  output logic          wr_active,
  output logic          byte_load,
  output logic [AW-1:0] byte_addr,
  output logic [DW-1:0] byte_data,
  output logic          rd_active,
  output logic          rd_done,
  output logic [AW-1:0] cur_addr
);
  logic          ce_q, we_q, oe_q, res_q, ws_prev, rd_prev;
  logic [AW-1:0] addr_q, lat_addr_q;
  logic [DW-1:0] din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      res_q   <= 1'b0;
      addr_q  <= '0;
      din_q   <= '0;
      ws_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      ce_q    <= ce_n;
      we_q    <= we_n;
      oe_q    <= oe_n;
      res_q   <= res_n;
      addr_q  <= addr;
      din_q   <= din;
      ws_prev <= wr_active;
      rd_prev <= rd_active;
    end
  end

  // address latch: enabled on the first cycle of a write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lat_addr_q <= '0;
    else if (wr_active && !ws_prev)  lat_addr_q <= addr_q;
  end

  assign res_ok    = res_q;
  assign wr_active = !ce_q && !we_q && res_q;
  assign rd_active = !ce_q && !oe_q && we_q && res_q;
  assign byte_load = ws_prev && !wr_active && res_q;
  assign rd_done   = rd_prev && !rd_active;
  assign byte_addr = lat_addr_q;
  assign byte_data = din_q;
  assign cur_addr  = addr_q;
endmodule

// File: rtl/eepw_seq.sv
// Load-window and program-cycle sequencer.
module eepw_seq
  import eepw_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int WIN_CYC    = 40,
  parameter int PROG_CYC   = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_ok,
  input  logic             wr_active,
  input  logic             byte_load,
  input  logic             rd_done,
  output logic             busy,
  output logic             in_prog,
  output logic             first_load,
  output logic             more_load,
  output logic             commit_en,
  output logic [$clog2(PAGE_BYTES)-1:0] commit_slot,
  output logic             status_tog
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CW    = $clog2(WIN_CYC + PROG_CYC + PAGE_BYTES + 1);

  sq_state_t      st_q, st_d;
  logic [CW-1:0]  tmr_q, tmr_d;
  logic           tog_q;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    case (st_q)
      SQ_IDLE: if (byte_load) begin
        st_d  = SQ_LOAD;
        tmr_d = '0;
      end
      SQ_LOAD: begin
        if (byte_load || wr_active) tmr_d = '0;
        else if (tmr_q == CW'(WIN_CYC - 1)) begin
          st_d  = SQ_PROG;
          tmr_d = '0;
        end else tmr_d = tmr_q + 1'b1;
      end
      SQ_PROG: begin
        if (tmr_q == CW'(PROG_CYC - 1)) begin
          st_d  = SQ_IDLE;
          tmr_d = '0;
        end else tmr_d = tmr_q + 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
    if (!res_ok) begin
      st_d  = SQ_IDLE;
      tmr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  // status flag: starts at 1 for a new session, flips after each busy read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tog_q <= 1'b1;
    else if (first_load)       tog_q <= 1'b1;
    else if (rd_done && busy)  tog_q <= !tog_q;
  end

  assign busy        = (st_q != SQ_IDLE);
  assign in_prog     = (st_q == SQ_PROG);
  assign first_load  = (st_q == SQ_IDLE) && byte_load;
  assign more_load   = (st_q == SQ_LOAD) && byte_load;
  assign commit_en   = in_prog && res_ok && (tmr_q < CW'(PAGE_BYTES));
  assign commit_slot = OFF_W'(tmr_q);
  assign status_tog  = tog_q;

  assert_prog_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == SQ_PROG) |-> $past(st_q) == SQ_LOAD);

  assert_abort_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ok |=> st_q == SQ_IDLE);
endmodule

// File: rtl/eepw_pagebuf.sv
// Page buffer with per-byte valid mask and page binding.
module eepw_pagebuf #(
  parameter int AW         = 17,
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          first_load,
  input  logic                          more_load,
  input  logic                          byte_load,
  input  logic                          in_prog,
  input  logic [AW-1:0]                 byte_addr,
  input  logic [DW-1:0]                 byte_data,
  input  logic [$clog2(PAGE_BYTES)-1:0] commit_slot,
  output logic [AW-$clog2(PAGE_BYTES)-1:0] page_base,
  output logic                          slot_valid,
  output logic [DW-1:0]                 slot_data,
  output logic                          last_msb,
  output logic                          page_err
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = AW - OFF_W;

  logic [DW-1:0]         data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [PG_W-1:0]       page_q;
  logic                  err_q, msb_q;

  logic [OFF_W-1:0] off;
  logic [PG_W-1:0]  pg;
  logic             same_pg, store;

  assign off     = byte_addr[OFF_W-1:0];
  assign pg      = byte_addr[AW-1:OFF_W];
  assign same_pg = (pg == page_q);
  assign store   = first_load || (more_load && same_pg);

  always_ff @(posedge clk) begin
    if (store) data_q[off] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      page_q  <= '0;
      err_q   <= 1'b0;
      msb_q   <= 1'b0;
    end else if (first_load) begin
      valid_q      <= '0;
      valid_q[off] <= 1'b1;
      page_q       <= pg;
      err_q        <= 1'b0;
      msb_q        <= byte_data[DW-1];
    end else if (more_load) begin
      if (same_pg) begin
        valid_q[off] <= 1'b1;
        msb_q        <= byte_data[DW-1];
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign page_base  = page_q;
  assign slot_valid = valid_q[commit_slot];
  assign slot_data  = data_q[commit_slot];
  assign last_msb   = msb_q;
  assign page_err   = err_q;

  assert_buf_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_prog && byte_load |=> $stable(valid_q));

  assert_err_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(more_load));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int AW         = 17,
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 128,
  parameter int MEM_DEPTH  = 1024,
  parameter int WIN_CYC    = 40,
  parameter int PROG_CYC   = 160
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          busy_pull,
  output logic          page_err
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = AW - OFF_W;
  localparam int MEM_AW = $clog2(MEM_DEPTH);

  logic             res_ok, wr_active, byte_load, rd_active, rd_done;
  logic [AW-1:0]    byte_addr, cur_addr;
  logic [DW-1:0]    byte_data, slot_data, status_byte;
  logic             busy, in_prog, first_load, more_load, commit_en, tog;
  logic [OFF_W-1:0] commit_slot;
  logic [PG_W-1:0]  page_base;
  logic             slot_valid, last_msb;
  logic [AW-1:0]    wr_full;
  logic [MEM_AW-1:0] wr_idx, rd_idx;
  logic [DW-1:0]    mem_q [MEM_DEPTH];

  eepw_strobe #(.AW(AW), .DW(DW)) u_strobe (
    .clk, .rst_n, .res_n, .ce_n, .we_n, .oe_n, .addr, .din,
    .res_ok, .wr_active, .byte_load, .byte_addr, .byte_data,
    .rd_active, .rd_done, .cur_addr
  );

  eepw_seq #(.PAGE_BYTES(PAGE_BYTES), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk, .rst_n, .res_ok, .wr_active, .byte_load, .rd_done,
    .busy, .in_prog, .first_load, .more_load, .commit_en, .commit_slot,
    .status_tog(tog)
  );

  eepw_pagebuf #(.AW(AW), .DW(DW), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk, .rst_n, .first_load, .more_load, .byte_load, .in_prog,
    .byte_addr, .byte_data, .commit_slot,
    .page_base, .slot_valid, .slot_data, .last_msb, .page_err
  );

  assign wr_full = {page_base, commit_slot};
  assign wr_idx  = MEM_AW'(wr_full);
  assign rd_idx  = MEM_AW'(cur_addr);

  // behavioural array: one page slot per cycle during programming
  always_ff @(posedge clk) begin
    if (commit_en && slot_valid) mem_q[wr_idx] <= slot_data;
  end

  always_comb begin
    status_byte       = '0;
    status_byte[DW-1] = !last_msb;
    status_byte[DW-2] = tog;
  end

  assign dout      = busy ? status_byte : mem_q[rd_idx];
  assign dout_en   = rd_active;
  assign busy_pull = busy;

  assert_busy_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull) |-> $past(byte_load));
endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;
  localparam int WIN  = 40;
  localparam int PROG = 160;

  logic        clk = 1'b0;
  logic        rst_n, res_n, ce_n, we_n, oe_n;
  logic [16:0] addr;
  logic [7:0]  din, dout;
  logic        dout_en, busy_pull, page_err;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2.5 clk = !clk;

  eeprom_page_writer #(.WIN_CYC(WIN), .PROG_CYC(PROG)) uut (
    .clk, .rst_n, .res_n, .ce_n, .we_n, .oe_n, .addr, .din,
    .dout, .dout_en, .busy_pull, .page_err
  );

  // {address, data}: one page, offsets 0..7
  localparam logic [24:0] LOAD_TAB [0:7] = '{
    {17'h00A00, 8'h11}, {17'h00A01, 8'h9C}, {17'h00A02, 8'h00}, {17'h00A03, 8'hFF},
    {17'h00A04, 8'h5A}, {17'h00A05, 8'hA5}, {17'h00A06, 8'h3C}, {17'h00A07, 8'hC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] d, output logic en);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_pull && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       en;
    int         n;
    rst_n = 1'b0; res_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy", busy_pull, 0);
    chk("R1 dout_en", dout_en, 0);
    chk("R1 page_err", page_err, 0);

    // page load from table, status reads while busy
    for (int i = 0; i < 8; i++) wr(LOAD_TAB[i][24:8], LOAD_TAB[i][7:0]);
    chk("R5 busy after load", busy_pull, 1);
    rd(17'h00A00, d, en);
    chk("R6 status first", d, 8'h40);
    rd(17'h00A00, d, en);
    chk("R6 status second", d, 8'h00);
    rd(17'h00A00, d, en);
    chk("R6 status third", d, 8'h40);
    wait_idle(n);
    for (int i = 0; i < 8; i++) begin
      rd(LOAD_TAB[i][24:8], d, en);
      chk("R2 R10 readback", {en, d}, {1'b1, LOAD_TAB[i][7:0]});
    end

    // partial page keeps neighbours
    wr(17'h00A02, 8'h77);
    wait_idle(n);
    rd(17'h00A01, d, en); chk("R3 neighbour below", d, 8'h9C);
    rd(17'h00A02, d, en); chk("R3 loaded byte", d, 8'h77);
    rd(17'h00A03, d, en); chk("R3 neighbour above", d, 8'hFF);

    // busy duration from the last load
    wr(17'h00100, 8'h42);
    chk("R5 busy set", busy_pull, 1);
    wait_idle(n);
    chk("R5 duration lo", (n >= WIN + PROG - 2), 1);
    chk("R5 duration hi", (n <= WIN + PROG + 2), 1);
    rd(17'h00100, d, en); chk("R2 single byte", d, 8'h42);

    // capture points: address at strobe start, data at strobe end
    addr = 17'h00180; din = 8'h12; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = 17'h00181; din = 8'h34;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
    wait_idle(n);
    rd(17'h00180, d, en); chk("R4 capture", d, 8'h34);

    // page binding and sticky error
    wr(17'h00400, 8'h01);
    wait_idle(n);
    wr(17'h00300, 8'hAB);
    wr(17'h00400, 8'hCD);
    chk("R7 err set", page_err, 1);
    wait_idle(n);
    chk("R7 err sticky", page_err, 1);
    rd(17'h00300, d, en); chk("R7 first kept", d, 8'hAB);
    rd(17'h00400, d, en); chk("R7 dropped byte", d, 8'h01);
    wr(17'h00405, 8'h02);
    chk("R7 err cleared", page_err, 0);
    wait_idle(n);

    // writes during the program cycle
    wr(17'h00500, 8'h10);
    repeat (WIN + 10) @(negedge clk);
    wr(17'h00A04, 8'hEE);
    wait_idle(n);
    rd(17'h00A04, d, en); chk("R9 ignored write", d, 8'h5A);

    // protect input: abort load, block reads and writes
    wr(17'h00A05, 8'h99);
    res_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 busy released", busy_pull, 0);
    rd(17'h00A05, d, en); chk("R8 read blocked", en, 0);
    wr(17'h00A06, 8'h55);
    chk("R8 write ignored", busy_pull, 0);
    res_n = 1'b1;
    repeat (WIN + PROG + 10) @(negedge clk);
    chk("R8 still idle", busy_pull, 0);
    rd(17'h00A05, d, en); chk("R8 aborted byte", d, 8'hA5);
    rd(17'h00A06, d, en); chk("R8 blocked byte", d, 8'h3C);

    // read enable needs chip select
    addr = 17'h00A00; ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk("R10 no select", dout_en, 0);
    oe_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule